// File: doc/BRIEF.md
# Vectored Interrupt Priority Arbiter

This block collects interrupt events from a set of maskable sources and one non-maskable software trap. It keeps a pending flag for each of them. When the core asks for a vector, it returns an even offset into a vector table. That offset identifies the highest-priority request that is active at that moment. Each maskable source has its own enable input, and a single global enable gates all of them. The trap ignores every enable. Its pending flag is internal, so it can only be seen through the request line and the returned offset.

The core watches `irq_o` to learn that service is wanted. It pulses `vec_req_i` for one cycle and reads `vec_off_o` on the following cycle, when `vec_valid_o` is high. The table slots are spaced two bytes apart, from the base offset upward. Slot 0 (the base) is the default slot, used when nothing is active. Source i uses slot i+1. The trap uses the top slot, which is the base plus 2*(NUM_SRC+1). With the default parameters this gives offsets from 0xE0 (default) through 0xE2..0xFC (sources 0..13) up to 0xFE (trap). Reading the table, pushing state and decoding instructions are handled elsewhere.

Top module: `vec_irq_arbiter`

## Requirements
- R1: After reset, every pending flag (including the trap's) is clear, `irq_o` is 0, `vec_valid_o` is 0 and `vec_off_o` holds the default offset 0xE0.
- R2: A 1 on `src_event_i[i]` at a clock edge sets pending flag i, and a 1 on `pend_clr_i[i]` clears it. If both are 1 at the same edge, the flag ends up set.
- R3: Source i is active only when its pending flag, `src_en_i[i]` and `glb_en_i` are all 1. `irq_o` is 1 exactly when at least one source is active or the trap is pending.
- R4: A 1 on `vec_req_i` at an edge makes `vec_valid_o` 1 for exactly the next cycle. At that same edge, `vec_off_o` takes the offset chosen from the state held before the edge. Source i maps to 0xE2 + 2*i, and a higher index wins.
- R5: A request made while no source is active and the trap is not pending returns the default offset 0xE0.
- R6: A 1 on `trap_req_i` sets the hidden trap flag. While that flag is set, a request returns 0xFE, whatever the state of `glb_en_i` or any maskable source.
- R7: A request that returns 0xFE clears the trap flag, unless `trap_req_i` is 1 at that same edge. Serving a maskable source leaves its pending flag unchanged.
- R8: `vec_off_o` changes only at an edge where `vec_req_i` is 1. Events arriving at or after the request edge do not affect the offset that request returns.
- R9: An event on a source whose enable (local or global) is 0 is still latched. When the enable later goes to 1, the source becomes active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| src_event_i | input | NUM_SRC | Per-source event; sets its pending flag |
| pend_clr_i | input | NUM_SRC | Per-source pending clear |
| src_en_i | input | NUM_SRC | Per-source enable |
| glb_en_i | input | 1 | Global enable for all maskable sources |
| trap_req_i | input | 1 | Software trap event (non-maskable) |
| vec_req_i | input | 1 | Vector request from the core |
| irq_o | output | 1 | Interrupt request to the core |
| vec_valid_o | output | 1 | Offset valid, one cycle after a request |
| vec_off_o | output | 8 | Even vector-table offset |

## Verification
The hardest case to reach from the ports is a request that serves the trap at the same edge where a fresh trap event arrives. The flag must then stay set, and the only evidence of that is a second request that again returns 0xFE. The bench lines both pulses up on one negative edge, and then issues a further request to expose the hidden flag. A second hard case is a pending source hidden by a mask. The bench latches events with the enables low, checks that requests return the default slot, and then raises the enables to show the event was kept.

// File: rtl/vip_pkg.sv
package vip_pkg;

   localparam int unsigned SLOT_STRIDE = 2;

   typedef logic [7:0] vec_off_t;

   // Offset of table slot 'slot' above base 'base'
   function automatic vec_off_t slot_off(vec_off_t base, int unsigned slot);
      return base + vec_off_t'(SLOT_STRIDE * slot);
   endfunction

endpackage

// File: rtl/vip_pend_bank.sv
module vip_pend_bank #(
   parameter int unsigned NUM_SRC = 14
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] set_i,
   input  logic [NUM_SRC-1:0] clr_i,
   output logic [NUM_SRC-1:0] pend_o
);

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
      always_ff @(posedge clk_i) begin
         if (!rst_ni)          pend_o[g] <= 1'b0;
         else if (set_i[g])    pend_o[g] <= 1'b1;
         else if (clr_i[g])    pend_o[g] <= 1'b0;
      end

      AST_EVENT_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
         set_i[g] |=> pend_o[g]); // R2
      AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (clr_i[g] && !set_i[g]) |=> !pend_o[g]); // R2
   end

endmodule

// File: rtl/vip_trap_flag.sv
module vip_trap_flag (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic trap_req_i,
   input  logic served_i,
   output logic trap_pend_o
);

   always_ff @(posedge clk_i) begin
      if (!rst_ni)         trap_pend_o <= 1'b0;
      else if (trap_req_i) trap_pend_o <= 1'b1;
      else if (served_i)   trap_pend_o <= 1'b0;
   end

   AST_TRAP_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (served_i && !trap_req_i) |=> !trap_pend_o); // R7
   AST_TRAP_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trap_req_i |=> trap_pend_o); // R6

endmodule

// File: rtl/vip_prio_enc.sv
module vip_prio_enc
   import vip_pkg::*;
#(
   parameter int unsigned NUM_SRC   = 14,
   parameter vec_off_t    VEC_BASE  = 8'hE0,
   parameter bit          SCAN_DOWN = 1'b0
) (
   input  logic [NUM_SRC-1:0] active_i,
   input  logic               trap_i,
   output vec_off_t           off_o
);

   localparam vec_off_t TRAP_OFF = slot_off(VEC_BASE, NUM_SRC + 1);

   if (SCAN_DOWN) begin : g_down
      logic found;
      always_comb begin
         found = trap_i;
         off_o = trap_i ? TRAP_OFF : VEC_BASE;
         for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (!found && active_i[i]) begin
               off_o = slot_off(VEC_BASE, i + 1);
               found = 1'b1;
            end
         end
      end
   end else begin : g_up
      always_comb begin
         off_o = VEC_BASE;
         for (int i = 0; i < NUM_SRC; i++) begin
            if (active_i[i]) off_o = slot_off(VEC_BASE, i + 1);
         end
         if (trap_i) off_o = TRAP_OFF;
      end
   end

endmodule

// File: rtl/vec_irq_arbiter.sv
module vec_irq_arbiter
   import vip_pkg::*;
#(
   parameter int unsigned NUM_SRC   = 14,
   parameter vec_off_t    VEC_BASE  = 8'hE0,
   parameter bit          SCAN_DOWN = 1'b0
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] src_event_i,
   input  logic [NUM_SRC-1:0] pend_clr_i,
   input  logic [NUM_SRC-1:0] src_en_i,
   input  logic               glb_en_i,
   input  logic               trap_req_i,
   input  logic               vec_req_i,
   output logic               irq_o,
   output logic               vec_valid_o,
   output logic [7:0]         vec_off_o
);

   localparam int unsigned TOP_SLOT = NUM_SRC + 1;
   localparam vec_off_t    TRAP_OFF = slot_off(VEC_BASE, TOP_SLOT);

   if (NUM_SRC < 1) begin : g_bad_count
      $error("vec_irq_arbiter: NUM_SRC must be at least 1");
   end
   if (VEC_BASE[0] != 1'b0) begin : g_bad_base
      $error("vec_irq_arbiter: VEC_BASE must be even");
   end
   if (int'(VEC_BASE) + int'(SLOT_STRIDE * TOP_SLOT) > 255) begin : g_bad_span
      $error("vec_irq_arbiter: table does not fit in an 8-bit offset");
   end

   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] active;
   logic               trap_pend;
   logic               trap_served;
   vec_off_t           enc_off;

   vip_pend_bank #(.NUM_SRC(NUM_SRC)) pend_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (src_event_i),
      .clr_i  (pend_clr_i),
      .pend_o (pend)
   );

   vip_trap_flag trap_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .trap_req_i  (trap_req_i),
      .served_i    (trap_served),
      .trap_pend_o (trap_pend)
   );

   assign active      = pend & src_en_i & {NUM_SRC{glb_en_i}};
   assign irq_o       = (|active) | trap_pend;
   assign trap_served = vec_req_i & trap_pend;

   vip_prio_enc #(
      .NUM_SRC   (NUM_SRC),
      .VEC_BASE  (VEC_BASE),
      .SCAN_DOWN (SCAN_DOWN)
   ) enc_i (
      .active_i (active),
      .trap_i   (trap_pend),
      .off_o    (enc_off)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         vec_valid_o <= 1'b0;
         vec_off_o   <= VEC_BASE;
      end else begin
         vec_valid_o <= vec_req_i;
         if (vec_req_i) vec_off_o <= enc_off;
      end
   end

   AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vec_req_i |=> vec_valid_o); // R4
   AST_VALID_ONLY_ON_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !vec_req_i |=> !vec_valid_o); // R4
   AST_OFF_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vec_valid_o |-> (vec_off_o[0] == 1'b0)); // R4
   AST_OFF_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !vec_req_i |=> $stable(vec_off_o)); // R8
   AST_TRAP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vec_req_i && trap_pend) |=> (vec_off_o == TRAP_OFF)); // R6
   AST_DEFAULT_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vec_req_i && !irq_o) |=> (vec_off_o == VEC_BASE)); // R5

endmodule

// File: tb/vec_irq_arbiter_tb_top.sv
module vec_irq_arbiter_tb_top;

   localparam int NS = 14;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] ev = '0;
   logic [NS-1:0] clr = '0;
   logic [NS-1:0] en = '0;
   logic          gie = 1'b0;
   logic          trap = 1'b0;
   logic          req = 1'b0;
   logic          irq;
   logic          vvalid;
   logic [7:0]    voff;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   vec_irq_arbiter #(.NUM_SRC(NS)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .src_event_i(ev), .pend_clr_i(clr),
      .src_en_i(en), .glb_en_i(gie), .trap_req_i(trap), .vec_req_i(req),
      .irq_o(irq), .vec_valid_o(vvalid), .vec_off_o(voff)
   );

   function automatic logic [7:0] src_off(int idx);
      return 8'hE2 + 8'(2 * idx);
   endfunction

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      ev = '0; clr = '0; trap = 1'b0; req = 1'b0;
   endtask

   task automatic request(string tag, logic [7:0] exp);
      req = 1'b1;
      step();
      check({tag, " valid"}, 32'(vvalid), 32'd1);
      check({tag, " offset"}, 32'(voff), 32'(exp));
      step();
      check({tag, " valid drops"}, 32'(vvalid), 32'd0);
   endtask

   task automatic clean();
      clr = '1; gie = 1'b0; en = '0;
      step();
      while (irq) request("clean trap", 8'hFE);
   endtask

   task automatic t_reset();
      check("R1 irq", 32'(irq), 32'd0);
      check("R1 valid", 32'(vvalid), 32'd0);
      check("R1 offset", 32'(voff), 32'hE0);
      gie = 1'b1; en = '1;
      step();
      check("R1 no pending", 32'(irq), 32'd0);
      request("R1 R5 default", 8'hE0);
   endtask

   task automatic t_single();
      gie = 1'b1; en[3] = 1'b1; ev[3] = 1'b1;
      step();
      check("R2 R3 irq after event", 32'(irq), 32'd1);
      request("R4 source 3", src_off(3));
      check("R7 maskable kept", 32'(irq), 32'd1);
      clr[3] = 1'b1;
      step();
      check("R2 clear", 32'(irq), 32'd0);
      clean();
   endtask

   task automatic t_priority();
      gie = 1'b1; en = '1; ev[0] = 1'b1; ev[5] = 1'b1; ev[13] = 1'b1;
      step();
      request("R4 top source", src_off(13));
      clr[13] = 1'b1; step();
      request("R4 middle source", src_off(5));
      clr[5] = 1'b1; step();
      request("R4 lowest source", src_off(0));
      clean();
   endtask

   task automatic t_mask();
      gie = 1'b0; en[7] = 1'b1; ev[7] = 1'b1; ev[9] = 1'b1;
      step();
      check("R3 global mask irq", 32'(irq), 32'd0);
      request("R5 masked default", 8'hE0);
      gie = 1'b1;
      step();
      check("R9 latched under global mask", 32'(irq), 32'd1);
      request("R3 local mask hides 9", src_off(7));
      en[9] = 1'b1;
      step();
      request("R9 latched under local mask", src_off(9));
      clean();
   endtask

   task automatic t_set_wins();
      gie = 1'b1; en[2] = 1'b1; ev[2] = 1'b1; clr[2] = 1'b1;
      step();
      check("R2 set beats clear", 32'(irq), 32'd1);
      clean();
   endtask

   task automatic t_trap();
      gie = 1'b0; trap = 1'b1;
      step();
      check("R6 trap irq under mask", 32'(irq), 32'd1);
      request("R6 trap offset", 8'hFE);
      check("R7 trap cleared irq", 32'(irq), 32'd0);
      request("R7 after trap default", 8'hE0);
      gie = 1'b1; en[13] = 1'b1; ev[13] = 1'b1; trap = 1'b1;
      step();
      request("R6 trap beats source 13", 8'hFE);
      request("R7 source 13 still pending", src_off(13));
      clean();
   endtask

   task automatic t_trap_same_edge();
      trap = 1'b1;
      step();
      trap = 1'b1;
      request("R7 served with new trap", 8'hFE);
      check("R7 trap still pending", 32'(irq), 32'd1);
      request("R7 second trap service", 8'hFE);
      check("R7 trap finally clear", 32'(irq), 32'd0);
      clean();
   endtask

   task automatic t_hold();
      gie = 1'b1; en = '1; ev[3] = 1'b1;
      step();
      ev[10] = 1'b1;
      request("R8 event at request edge ignored", src_off(3));
      check("R8 offset held", 32'(voff), 32'(src_off(3)));
      clr[3] = 1'b1;
      step();
      step();
      check("R8 offset held after change", 32'(voff), 32'(src_off(3)));
      request("R8 new request sees 10", src_off(10));
      clean();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      t_reset();
      clean();
      t_single();
      t_priority();
      t_mask();
      t_set_wins();
      t_trap();
      t_trap_same_edge();
      t_hold();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule